// File: doc/BRIEF.md
# Eight-Point Parallel FFT Kernel

This block computes an eight-point complex discrete Fourier transform on a whole frame of samples every clock cycle. All eight complex fixed-point samples arrive together on one cycle with a valid flag. The eight spectral bins leave together a fixed three cycles later, with the valid flag following the data through the pipeline. It is meant to be tiled inside wider transform engines, or used alone where one short transform per clock is needed.

The arithmetic uses three columns of four radix-2 butterflies in the decimation-in-time arrangement, with the twiddle applied on the lower input of each butterfly. Samples enter in natural order and bins leave in bit-reversed slot order. The first column only adds and subtracts. The second column also rotates by -j, which is a swap of the real and imaginary parts plus one negation. The third column adds rotations by the eighth roots of unity: their 0.707 factor is the constant 181/256, built from shifted copies of the operand summed together and rounded half up. There is no general multiplier anywhere in the block. Each column widens the data by one bit, so W-bit inputs give (W+3)-bit outputs.

Top module: `fft8_par`

## Requirements
- R1: Output slot s, at bits [s*(W+3) +: W+3] of each output bus, holds bin X[k] with k the 3-bit reversal of s. Here X[k] = sum over n of x[n]*exp(-j*2*pi*n*k/8), and sample n sits at bits [n*W +: W] of each input bus. Every real and imaginary part is within 2 LSB of the exact value.
- R2: When in_valid is sampled high on a rising clock edge, out_valid is high after the third rising edge that follows and low again after the fourth, unless a later frame was accepted.
- R3: A new frame may be accepted on every clock cycle. Frames accepted on consecutive cycles come out on consecutive cycles, in order, each one correct.
- R4: A cycle with in_valid low leaves the output data unchanged and clears out_valid, whatever values the input buses carry.
- R5: Driving rst_n low clears out_valid at once. A frame accepted before or during the reset never raises out_valid.
- R6: A constant input (every sample equal to a+jb) gives exactly 8a+j8b in slot 0 and exactly zero in slots 1 to 7.
- R7: An input that is zero except for sample 0, equal to a+jb, gives exactly a+jb in every slot.
- R8: If every input sample has a complex magnitude below 2^(W-1), no butterfly sum overflows its stage width. A full-scale single tone then shows its peak, about eight times the sample magnitude, in the correct slot with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline; released in step with clk |
| in_valid | input | 1 | A new frame is present on in_re and in_im |
| in_re | input | 8*W | Real parts of samples 0..7, sample n at bits [n*W +: W], two's complement |
| in_im | input | 8*W | Imaginary parts of samples 0..7, same layout |
| out_valid | output | 1 | out_re and out_im hold the transform of a frame accepted three cycles earlier |
| out_re | output | 8*(W+3) | Real parts of the bins in bit-reversed slot order, two's complement |
| out_im | output | 8*(W+3) | Imaginary parts of the bins, same layout |

## Verification
The overflow assertion depends on the input frame staying within a complex magnitude of 2^(W-1). Any single part may reach full scale, but a sample whose real and imaginary parts are both near full scale may drive the third column past its width. The bench therefore keeps every part within ±1400 at W = 12, and it builds its full-scale tones with a radius of 1900, so the magnitude limit is always met. The hold assertion assumes rst_n is released away from the active clock edge. The bench changes rst_n only on falling edges.

// File: rtl/fft8_pkg.sv
package fft8_pkg;

  localparam int NPT  = 8;
  localparam int NSTG = 3;

  // Rotation applied on the lower leg of a butterfly.
  typedef enum logic [1:0] {
    TW_ONE  = 2'd0,  // multiply by 1
    TW_NEGJ = 2'd1,  // multiply by -j
    TW_W1   = 2'd2,  // multiply by 0.707(1-j)
    TW_W3   = 2'd3   // multiply by 0.707(-1-j)
  } tw_e;

  // Twiddle for the butterfly whose upper slot is lo in column stg.
  function automatic tw_e tw_sel(input int stg, input int lo);
    int idx;
    tw_sel = TW_ONE;
    if (stg == 1) begin
      if (((lo >> 2) & 1) == 1) tw_sel = TW_NEGJ;
    end else if (stg >= 2) begin
      idx = ((lo >> 2) & 1) + 2 * ((lo >> 1) & 1);
      case (idx)
        1:       tw_sel = TW_W1;
        2:       tw_sel = TW_NEGJ;
        3:       tw_sel = TW_W3;
        default: tw_sel = TW_ONE;
      endcase
    end
  endfunction

endpackage

// File: rtl/fft8_mul707.sv
// Constant multiply by 181/256 (about 0.7071) from shifted copies, round half up.
module fft8_mul707 #(
  parameter int WS = 14
) (
  input  logic signed [WS-1:0] x,
  output logic signed [WS-1:0] y
);

  localparam int WP   = WS + 8;
  localparam int HALF = 128;

  logic signed [WP-1:0] xe;
  logic signed [WP-1:0] prod;
  logic signed [WP-1:0] prod_rnd;

  always_comb begin
    xe       = {{8{x[WS-1]}}, x};
    prod     = (xe <<< 7) + (xe <<< 5) + (xe <<< 4) + (xe <<< 2) + xe;
    prod_rnd = prod + WP'(HALF);
    y        = prod_rnd[WS+7:8];
  end

endmodule

// File: rtl/fft8_bfly.sv
// One radix-2 butterfly: twiddle on the lower leg, registered outputs.
module fft8_bfly
  import fft8_pkg::*;
#(
  parameter int  WI = 12,
  parameter tw_e TW = TW_ONE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [WI-1:0] a_re,
  input  logic signed [WI-1:0] a_im,
  input  logic signed [WI-1:0] b_re,
  input  logic signed [WI-1:0] b_im,
  output logic signed [WI:0]   y0_re,
  output logic signed [WI:0]   y0_im,
  output logic signed [WI:0]   y1_re,
  output logic signed [WI:0]   y1_im
);

  localparam int WT = WI + 1;
  localparam int WS = WI + 2;

  logic signed [WT-1:0] a_re_x, a_im_x, b_re_x, b_im_x;
  logic signed [WT-1:0] t_re, t_im;
  logic signed [WS-1:0] s0_re, s0_im, s1_re, s1_im;
  logic signed [WT-1:0] y0_re_d, y0_im_d, y1_re_d, y1_im_d;
  logic signed [WT-1:0] y0_re_q, y0_im_q, y1_re_q, y1_im_q;

  assign a_re_x = {a_re[WI-1], a_re};
  assign a_im_x = {a_im[WI-1], a_im};
  assign b_re_x = {b_re[WI-1], b_re};
  assign b_im_x = {b_im[WI-1], b_im};

  generate
    if (TW == TW_ONE) begin : g_one
      assign t_re = b_re_x;
      assign t_im = b_im_x;
    end else if (TW == TW_NEGJ) begin : g_negj
      assign t_re = b_im_x;
      assign t_im = -b_re_x;
    end else begin : g_diag
      logic signed [WT-1:0] u_re, u_im;
      if (TW == TW_W1) begin : g_w1
        assign u_re = b_re_x + b_im_x;
        assign u_im = b_im_x - b_re_x;
      end else begin : g_w3
        assign u_re = b_im_x - b_re_x;
        assign u_im = -b_re_x - b_im_x;
      end
      fft8_mul707 #(.WS(WT)) u_mre (.x(u_re), .y(t_re));
      fft8_mul707 #(.WS(WT)) u_mim (.x(u_im), .y(t_im));
    end
  endgenerate

  // next-state
  always_comb begin
    s0_re   = WS'(a_re_x) + WS'(t_re);
    s0_im   = WS'(a_im_x) + WS'(t_im);
    s1_re   = WS'(a_re_x) - WS'(t_re);
    s1_im   = WS'(a_im_x) - WS'(t_im);
    y0_re_d = s0_re[WT-1:0];
    y0_im_d = s0_im[WT-1:0];
    y1_re_d = s1_re[WT-1:0];
    y1_im_d = s1_im[WT-1:0];
  end

  // register, clock-enabled, no data reset
  always_ff @(posedge clk) begin
    if (en) begin
      y0_re_q <= y0_re_d;
      y0_im_q <= y0_im_d;
      y1_re_q <= y1_re_d;
      y1_im_q <= y1_im_d;
    end
  end

  assign y0_re = y0_re_q;
  assign y0_im = y0_im_q;
  assign y1_re = y1_re_q;
  assign y1_im = y1_im_q;

  // Checks
  logic signed [WS-1:0] pair_re, pair_im, twice_a_re, twice_a_im;
  assign pair_re    = WS'(y0_re_q) + WS'(y1_re_q);
  assign pair_im    = WS'(y0_im_q) + WS'(y1_im_q);
  assign twice_a_re = WS'(a_re_x) <<< 1;
  assign twice_a_im = WS'(a_im_x) <<< 1;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((s0_re[WS-1] == s0_re[WS-2]) && (s0_im[WS-1] == s0_im[WS-2]) &&
            (s1_re[WS-1] == s1_re[WS-2]) && (s1_im[WS-1] == s1_im[WS-2])))
    else $error("butterfly sum exceeds stage width"); // R8

  AST_BFLY_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((pair_re == $past(twice_a_re)) && (pair_im == $past(twice_a_im))))
    else $error("butterfly outputs do not straddle upper input"); // R1

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(y0_re_q) && $stable(y0_im_q) && $stable(y1_re_q) && $stable(y1_im_q)))
    else $error("butterfly output moved without enable"); // R4

endmodule

// File: rtl/fft8_stage.sv
// One column of four butterflies plus its valid flop.
module fft8_stage
  import fft8_pkg::*;
#(
  parameter int WI  = 12,
  parameter int STG = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vld_i,
  input  logic [NPT*WI-1:0]     din_re,
  input  logic [NPT*WI-1:0]     din_im,
  output logic                  vld_o,
  output logic [NPT*(WI+1)-1:0] dout_re,
  output logic [NPT*(WI+1)-1:0] dout_im
);

  localparam int WO     = WI + 1;
  localparam int NBF    = NPT / 2;
  localparam int STRIDE = NBF >> STG;

  genvar p;
  generate
    for (p = 0; p < NBF; p++) begin : g_bf
      localparam int LO = (p / STRIDE) * 2 * STRIDE + (p % STRIDE);
      localparam int HI = LO + STRIDE;
      fft8_bfly #(.WI(WI), .TW(tw_sel(STG, LO))) u_bf (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (vld_i),
        .a_re  (din_re[LO*WI +: WI]),
        .a_im  (din_im[LO*WI +: WI]),
        .b_re  (din_re[HI*WI +: WI]),
        .b_im  (din_im[HI*WI +: WI]),
        .y0_re (dout_re[LO*WO +: WO]),
        .y0_im (dout_im[LO*WO +: WO]),
        .y1_re (dout_re[HI*WO +: WO]),
        .y1_im (dout_im[HI*WO +: WO])
      );
    end
  endgenerate

  logic vld_d, vld_q;

  always_comb vld_d = vld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign vld_o = vld_q;

  AST_STAGE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o) else $error("valid lost in column"); // R2

  AST_STAGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_o) else $error("valid raised without input"); // R4

endmodule

// File: rtl/fft8_par.sv
// Eight-point FFT, three registered butterfly columns, bit-reversed output.
module fft8_par
  import fft8_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NPT*W-1:0]     in_re,
  input  logic [NPT*W-1:0]     in_im,
  output logic                 out_valid,
  output logic [NPT*(W+3)-1:0] out_re,
  output logic [NPT*(W+3)-1:0] out_im
);

  localparam int W1 = W + 1;
  localparam int W2 = W + 2;

  logic                v1, v2;
  logic [NPT*W1-1:0]   s1_re, s1_im;
  logic [NPT*W2-1:0]   s2_re, s2_im;

  fft8_stage #(.WI(W), .STG(0)) u_col0 (
    .clk (clk), .rst_n (rst_n), .vld_i (in_valid),
    .din_re (in_re), .din_im (in_im),
    .vld_o (v1), .dout_re (s1_re), .dout_im (s1_im)
  );

  fft8_stage #(.WI(W1), .STG(1)) u_col1 (
    .clk (clk), .rst_n (rst_n), .vld_i (v1),
    .din_re (s1_re), .din_im (s1_im),
    .vld_o (v2), .dout_re (s2_re), .dout_im (s2_im)
  );

  fft8_stage #(.WI(W2), .STG(2)) u_col2 (
    .clk (clk), .rst_n (rst_n), .vld_i (v2),
    .din_re (s2_re), .din_im (s2_im),
    .vld_o (out_valid), .dout_re (out_re), .dout_im (out_im)
  );

endmodule

// File: tb/tb_fft8_par.sv
module tb_fft8_par;

  localparam int W          = 12;
  localparam int OW         = W + 3;
  localparam int CLK_PERIOD = 10;
  localparam int NV         = 6;
  localparam real PI        = 3.14159265358979;

  // rows: re[0..7] then im[0..7]
  localparam int STIM [NV][16] = '{
    '{1000, 0, 0, 0, 0, 0, 0, 0,      0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 1000, 0, 0, 0, 0, 0, 0,      0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 0, 0, 0, 0, 0, 0, 0,         0, 0, 0, 700, 0, 0, 0, 0},
    '{900, -900, 900, -900, 900, -900, 900, -900,  0, 0, 0, 0, 0, 0, 0, 0},
    '{-1400, -1000, -600, -200, 200, 600, 1000, 1400,  300, -300, 300, -300, 0, 0, 0, 0},
    '{123, -456, 789, -1011, 1213, -1314, 1001, -77,  -999, 555, -333, 1111, -1222, 44, 876, -1400}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [8*W-1:0]  in_re, in_im;
  logic            out_valid;
  logic [8*OW-1:0] out_re, out_im;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  int  xr [8];
  int  xi [8];
  real er [8];
  real ei [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  fft8_par #(.W(W)) dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .in_re (in_re), .in_im (in_im),
    .out_valid (out_valid), .out_re (out_re), .out_im (out_im)
  );

  function automatic int bitrev3(input int s);
    return ((s & 1) << 2) | (s & 2) | ((s >> 2) & 1);
  endfunction

  function automatic void calc_dft();
    for (int k = 0; k < 8; k++) begin
      er[k] = 0.0;
      ei[k] = 0.0;
      for (int n = 0; n < 8; n++) begin
        real th;
        th = 2.0 * PI * real'(n * k) / 8.0;
        er[k] += real'(xr[n]) * $cos(th) + real'(xi[n]) * $sin(th);
        ei[k] += real'(xi[n]) * $cos(th) - real'(xr[n]) * $sin(th);
      end
    end
  endfunction

  function automatic int slot_re(input int s);
    return $signed(out_re[s*OW +: OW]);
  endfunction

  function automatic int slot_im(input int s);
    return $signed(out_im[s*OW +: OW]);
  endfunction

  task automatic check_int(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_near(input string req, input string what, input int act, input real exp, input real tol);
    real d;
    n_chk++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > tol + 0.001) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %f", req, what, act, exp);
    end
  endtask

  // compare all slots against er/ei
  task automatic cmp_spectrum(input string req, input real tol);
    for (int s = 0; s < 8; s++) begin
      int k;
      k = bitrev3(s);
      check_near(req, $sformatf("slot %0d re (bin %0d)", s, k), slot_re(s), er[k], tol);
      check_near(req, $sformatf("slot %0d im (bin %0d)", s, k), slot_im(s), ei[k], tol);
    end
  endtask

  task automatic load_inputs();
    for (int n = 0; n < 8; n++) begin
      in_re[n*W +: W] = W'(xr[n]);
      in_im[n*W +: W] = W'(xi[n]);
    end
  endtask

  // called at a falling edge; returns at the falling edge where the result is due
  task automatic run_frame(input string req, input real tol);
    load_inputs();
    calc_dft();
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_int(req, "out_valid", int'(out_valid), 1);
    cmp_spectrum(req, tol);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_re    = '0;
    in_im    = '0;
    repeat (3) @(negedge clk);
    check_int("R5", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1, with R6/R7-style frames included
    for (int v = 0; v < NV; v++) begin
      for (int n = 0; n < 8; n++) begin
        xr[n] = STIM[v][n];
        xi[n] = STIM[v][8+n];
      end
      run_frame("R1", 2.0);
    end

    // R2: valid pulse timing
    for (int n = 0; n < 8; n++) begin xr[n] = 50 * n; xi[n] = -30 * n; end
    load_inputs();
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check_int("R2", "out_valid after edge 1", int'(out_valid), 0);
    @(negedge clk);
    check_int("R2", "out_valid after edge 2", int'(out_valid), 0);
    @(negedge clk);
    check_int("R2", "out_valid after edge 3", int'(out_valid), 1);
    @(negedge clk);
    check_int("R2", "out_valid after edge 4", int'(out_valid), 0);

    // R6: constant input, exact
    for (int n = 0; n < 8; n++) begin xr[n] = -1200; xi[n] = 1100; end
    run_frame("R6", 0.0);
    @(negedge clk);

    // R7: impulse at sample 0, exact
    for (int n = 0; n < 8; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = -1400; xi[0] = 1399;
    run_frame("R7", 0.0);

    // R4: inputs ignored while in_valid is low, outputs held
    begin
      int hold_re [8];
      int hold_im [8];
      for (int s = 0; s < 8; s++) begin hold_re[s] = slot_re(s); hold_im[s] = slot_im(s); end
      in_re = {8{12'h7A5}};
      in_im = {8{12'h85A}};
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_int("R4", "out_valid idle", int'(out_valid), 0);
      for (int s = 0; s < 8; s++) begin
        check_int("R4", $sformatf("slot %0d re held", s), slot_re(s), hold_re[s]);
        check_int("R4", $sformatf("slot %0d im held", s), slot_im(s), hold_im[s]);
      end
    end

    // R8: full-scale tones in every bin
    for (int b = 0; b < 8; b++) begin
      for (int n = 0; n < 8; n++) begin
        real th;
        th = 2.0 * PI * real'(n * b) / 8.0;
        xr[n] = $rtoi(1900.0 * $cos(th));
        xi[n] = $rtoi(1900.0 * $sin(th));
      end
      run_frame("R8", 2.0);
      @(negedge clk);
    end

    // R3: back-to-back frames
    begin
      real br [4][8];
      real bi [4][8];
      int  bxr [4][8];
      int  bxi [4][8];
      for (int f = 0; f < 4; f++) begin
        for (int n = 0; n < 8; n++) begin
          bxr[f][n] = int'($urandom_range(2800)) - 1400;
          bxi[f][n] = int'($urandom_range(2800)) - 1400;
          xr[n] = bxr[f][n];
          xi[n] = bxi[f][n];
        end
        calc_dft();
        for (int k = 0; k < 8; k++) begin br[f][k] = er[k]; bi[f][k] = ei[k]; end
      end
      for (int c = 0; c < 8; c++) begin
        if (c >= 3 && c < 7) begin
          check_int("R3", "out_valid in burst", int'(out_valid), 1);
          for (int k = 0; k < 8; k++) begin er[k] = br[c-3][k]; ei[k] = bi[c-3][k]; end
          cmp_spectrum("R3", 2.0);
        end
        if (c < 4) begin
          for (int n = 0; n < 8; n++) begin xr[n] = bxr[c][n]; xi[n] = bxi[c][n]; end
          load_inputs();
          in_valid = 1'b1;
        end else begin
          in_valid = 1'b0;
        end
        @(negedge clk);
      end
      check_int("R3", "out_valid after burst", int'(out_valid), 0);
    end

    // R5: reset in flight kills the frame
    for (int n = 0; n < 8; n++) begin xr[n] = 333; xi[n] = -333; end
    load_inputs();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    #1;
    check_int("R5", "out_valid right after reset", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check_int("R5", $sformatf("out_valid %0d cycles after release", c + 1), int'(out_valid), 0);
    end

    // random frames after reset still correct (R1)
    for (int v = 0; v < 20; v++) begin
      for (int n = 0; n < 8; n++) begin
        xr[n] = int'($urandom_range(2800)) - 1400;
        xi[n] = int'($urandom_range(2800)) - 1400;
      end
      run_frame("R1", 2.0);
    end

    finish_run();
  end

endmodule